// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block watches a host processor through a periodic trigger. After the host has been held in reset for a fixed time, the block waits for the host to confirm it is running by pulling the mode input low. It then enforces a timing window on every trigger. A blocked interval comes first, in which any trigger is a fault. An open interval follows, in which exactly one good trigger must arrive. A fault, a missing trigger or a handshake timeout produces a reset pulse of fixed length toward the host. After the pulse the block goes back to waiting for the handshake.

Two window pairs exist. A short pair is used while the host is active. A long pair is used while the host sleeps. In sleep, a wake edge ends the long window with a reset pulse, which restarts the host. A peripheral-enable output turns on only after three consecutive accepted short-mode triggers, so that safety-relevant loads follow the health of the host.

All inputs arrive already debounced and as single-cycle pulses where appropriate. Every duration is a parameter in clock cycles. Reset polarity toward the pin is handled outside the block.

Top module: `wdg_window_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `host_rst_o` is 1 and `periph_en_o` is 0 after that edge.
- R2: After `rst_n` is released, `host_rst_o` stays 1 for exactly T_PWRUP cycles and then falls.
- R3: In the handshake state, `mode_i` low moves the block into the short blocked interval at the next edge. If `mode_i` stays high for T_MODESW cycles, a reset pulse starts.
- R4: Every reset pulse keeps `host_rst_o` at 1 for exactly T_RSTPULSE cycles. The block then returns to the handshake state.
- R5: In short mode the blocked interval lasts T_SHORT_DIS cycles and the open interval lasts T_SHORT_EN cycles. A `trig_ok_i` pulse in any open cycle, including the last one, is accepted and restarts the blocked interval.
- R6: A reset pulse starts on any of these: `trig_ok_i` or `trig_err_i` in a blocked cycle (including its last one), `trig_err_i` in an open cycle, or no accepted trigger by the end of the open interval. When `trig_err_i` and `trig_ok_i` arrive together, the error wins.
- R7: Long mode uses T_LONG_DIS blocked cycles and T_LONG_EN open cycles, with the trigger rules of R5 and R6.
- R8: `mode_i` high in the short blocked interval switches to the long blocked interval. `mode_i` low in the long blocked interval switches to the short blocked interval. `mode_i` is ignored in the open intervals.
- R9: `wake_edge_i` in either long-mode state starts a reset pulse. It has no effect in short mode or in the handshake state.
- R10: `periph_en_o` rises together with the third consecutive accepted short-mode trigger. The count saturates at three.
- R11: When a reset pulse starts, `periph_en_o` falls in the same cycle, and the trigger count restarts from zero.
- R12: `periph_en_o` is 0 in every long-mode cycle. The trigger count is kept across a mode switch, so enable comes back on return to short mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mode_i | input | 1 | Debounced mode level: 0 = active (short window), 1 = sleep (long window) |
| trig_ok_i | input | 1 | One-cycle pulse: good trigger edge seen |
| trig_err_i | input | 1 | One-cycle pulse: malformed trigger seen |
| wake_edge_i | input | 1 | One-cycle pulse: edge on the wake input |
| host_rst_o | output | 1 | Registered active-high reset toward the host |
| periph_en_o | output | 1 | Registered peripheral enable |

## Verification
The bench places triggers on both sides of each window edge: the last blocked cycle, the first open cycle and the last open cycle. A design that counted one interval a cycle short or long would reset on a good trigger or accept a bad one. It drives an error together with a good trigger, sends wake edges in short mode, in long mode and during the handshake, and raises mode inside an open interval. A design with the wrong priority or a leaky mode switch would show a reset pulse where none belongs, or miss one. The enable sequence is broken at each step and resumed after a long-mode detour, so a counter that is not cleared on a fault, or is cleared on a mode change, shows up as a wrong enable level.

// File: rtl/wdg_pkg.sv
// Package: shared state encoding for the window watchdog supervisor.
// Assumes a single clock domain; values are compared only inside this block.
package wdg_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_MODESW,
        ST_SDIS,
        ST_SEN,
        ST_LDIS,
        ST_LEN,
        ST_RSTOUT
    } wdg_state_e;
endpackage

// File: rtl/wdg_interval_timer.sv
// Module: interval down-counter. It reloads whenever the supervisor enters a
// new state and reports when the final cycle of that state is reached.
// Assumes the load value is (duration - 1) and that the duration is at least 1.
module wdg_interval_timer #(
    parameter int W       = 17,
    parameter int RST_VAL = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // Reload on state entry, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wdg_fsm.sv
// Module: supervisor state machine. It decides the next state from the mode
// level, the trigger pulses, the wake pulse and the timer, and registers the
// host reset. Assumes the inputs are debounced and the pulses last one cycle.
module wdg_fsm
    import wdg_pkg::*;
#(
    parameter int W           = 17,
    parameter int T_PWRUP     = 201,
    parameter int T_MODESW    = 1112,
    parameter int T_SHORT_DIS = 130,
    parameter int T_SHORT_EN  = 124,
    parameter int T_LONG_DIS  = 71970,
    parameter int T_LONG_EN   = 30002,
    parameter int T_RSTPULSE  = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         trig_ok_i,
    input  logic         trig_err_i,
    input  logic         wake_edge_i,
    input  logic         expired_i,
    output logic         load_o,
    output logic [W-1:0] load_val_o,
    output wdg_state_e   state_o,
    output logic         good_trig_o,
    output logic         fault_o,
    output logic         short_nxt_o,
    output logic         host_rst_o
);
    localparam logic [W-1:0] LD_PWRUP  = W'(T_PWRUP - 1);
    localparam logic [W-1:0] LD_MODESW = W'(T_MODESW - 1);
    localparam logic [W-1:0] LD_SDIS   = W'(T_SHORT_DIS - 1);
    localparam logic [W-1:0] LD_SEN    = W'(T_SHORT_EN - 1);
    localparam logic [W-1:0] LD_LDIS   = W'(T_LONG_DIS - 1);
    localparam logic [W-1:0] LD_LEN    = W'(T_LONG_EN - 1);
    localparam logic [W-1:0] LD_RST    = W'(T_RSTPULSE - 1);

    wdg_state_e state_q, state_nxt;
    logic       rst_q;

    // Next state: faults first, then mode changes, then timeouts.
    always_comb begin
        state_nxt = state_q;
        case (state_q)
            ST_PWRUP:  if (expired_i) state_nxt = ST_MODESW;
            ST_MODESW: begin
                if (!mode_i)         state_nxt = ST_SDIS;
                else if (expired_i)  state_nxt = ST_RSTOUT;
            end
            ST_SDIS: begin
                if (trig_ok_i || trig_err_i) state_nxt = ST_RSTOUT;
                else if (mode_i)             state_nxt = ST_LDIS;
                else if (expired_i)          state_nxt = ST_SEN;
            end
            ST_SEN: begin
                if (trig_err_i)      state_nxt = ST_RSTOUT;
                else if (trig_ok_i)  state_nxt = ST_SDIS;
                else if (expired_i)  state_nxt = ST_RSTOUT;
            end
            ST_LDIS: begin
                if (wake_edge_i || trig_ok_i || trig_err_i) state_nxt = ST_RSTOUT;
                else if (!mode_i)                           state_nxt = ST_SDIS;
                else if (expired_i)                         state_nxt = ST_LEN;
            end
            ST_LEN: begin
                if (wake_edge_i || trig_err_i) state_nxt = ST_RSTOUT;
                else if (trig_ok_i)            state_nxt = ST_LDIS;
                else if (expired_i)            state_nxt = ST_RSTOUT;
            end
            ST_RSTOUT: if (expired_i) state_nxt = ST_MODESW;
            default:   state_nxt = ST_PWRUP;
        endcase
    end

    // Timer reload value for the state being entered.
    always_comb begin
        case (state_nxt)
            ST_MODESW: load_val_o = LD_MODESW;
            ST_SDIS:   load_val_o = LD_SDIS;
            ST_SEN:    load_val_o = LD_SEN;
            ST_LDIS:   load_val_o = LD_LDIS;
            ST_LEN:    load_val_o = LD_LEN;
            ST_RSTOUT: load_val_o = LD_RST;
            default:   load_val_o = LD_PWRUP;
        endcase
    end

    // State and host reset registers; reset is aligned with the state it shows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            rst_q   <= 1'b1;
        end else begin
            state_q <= state_nxt;
            rst_q   <= (state_nxt == ST_PWRUP) || (state_nxt == ST_RSTOUT);
        end
    end

    assign load_o      = (state_nxt != state_q);
    assign state_o     = state_q;
    assign good_trig_o = (state_q == ST_SEN) && trig_ok_i && !trig_err_i;
    assign fault_o     = (state_nxt == ST_RSTOUT) && (state_q != ST_RSTOUT);
    assign short_nxt_o = (state_nxt == ST_SDIS) || (state_nxt == ST_SEN);
    assign host_rst_o  = rst_q;
endmodule

// File: rtl/wdg_enable_gate.sv
// Module: counts consecutive accepted short-mode triggers and drives the
// registered peripheral enable. Assumes fault_i marks the first cycle of a
// reset pulse and short_nxt_i the short-mode states of the next cycle.
module wdg_enable_gate #(
    parameter int GOOD_TRIG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good_trig_i,
    input  logic fault_i,
    input  logic short_nxt_i,
    output logic en_o
);
    localparam int CW = $clog2(GOOD_TRIG + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(GOOD_TRIG);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          en_q;

    // Saturating count; any fault restarts it.
    always_comb begin
        cnt_nxt = cnt_q;
        if (fault_i)
            cnt_nxt = '0;
        else if (good_trig_i && cnt_q != CNT_MAX)
            cnt_nxt = cnt_q + 1'b1;
    end

    // Count and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            en_q  <= short_nxt_i && (cnt_nxt == CNT_MAX);
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/wdg_window_supervisor.sv
// Module: top of the window watchdog supervisor. It joins the state machine,
// the shared interval timer and the enable gate. Assumes all durations are at
// least one cycle and that the inputs are debounced in the clk domain.
module wdg_window_supervisor
    import wdg_pkg::*;
#(
    parameter int T_PWRUP     = 201,
    parameter int T_MODESW    = 1112,
    parameter int T_SHORT_DIS = 130,
    parameter int T_SHORT_EN  = 124,
    parameter int T_LONG_DIS  = 71970,
    parameter int T_LONG_EN   = 30002,
    parameter int T_RSTPULSE  = 40,
    parameter int GOOD_TRIG   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic trig_ok_i,
    input  logic trig_err_i,
    input  logic wake_edge_i,
    output logic host_rst_o,
    output logic periph_en_o
);
    localparam int M1   = (T_PWRUP > T_MODESW) ? T_PWRUP : T_MODESW;
    localparam int M2   = (T_SHORT_DIS > T_SHORT_EN) ? T_SHORT_DIS : T_SHORT_EN;
    localparam int M3   = (T_LONG_DIS > T_LONG_EN) ? T_LONG_DIS : T_LONG_EN;
    localparam int M4   = (M1 > M2) ? M1 : M2;
    localparam int M5   = (M3 > T_RSTPULSE) ? M3 : T_RSTPULSE;
    localparam int MAXD = (M4 > M5) ? M4 : M5;
    localparam int W    = $clog2(MAXD + 1);

    logic         load, expired, good_trig, fault, short_nxt;
    logic [W-1:0] load_val;
    wdg_state_e   state_q;

    wdg_interval_timer #(.W(W), .RST_VAL(T_PWRUP - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
        .expired_o(expired)
    );

    wdg_fsm #(
        .W(W), .T_PWRUP(T_PWRUP), .T_MODESW(T_MODESW),
        .T_SHORT_DIS(T_SHORT_DIS), .T_SHORT_EN(T_SHORT_EN),
        .T_LONG_DIS(T_LONG_DIS), .T_LONG_EN(T_LONG_EN), .T_RSTPULSE(T_RSTPULSE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_ok_i(trig_ok_i),
        .trig_err_i(trig_err_i), .wake_edge_i(wake_edge_i), .expired_i(expired),
        .load_o(load), .load_val_o(load_val), .state_o(state_q),
        .good_trig_o(good_trig), .fault_o(fault), .short_nxt_o(short_nxt),
        .host_rst_o(host_rst_o)
    );

    wdg_enable_gate #(.GOOD_TRIG(GOOD_TRIG)) u_gate (
        .clk(clk), .rst_n(rst_n), .good_trig_i(good_trig), .fault_i(fault),
        .short_nxt_i(short_nxt), .en_o(periph_en_o)
    );
endmodule

// File: rtl/wdg_window_checker.sv
// Module: property checker for the supervisor, attached by bind. Assumes it
// sees the registered state of the supervisor and its ports.
module wdg_window_checker
    import wdg_pkg::*;
#(
    parameter int T_RSTPULSE = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_i,
    input logic       wake_edge_i,
    input logic       host_rst_o,
    input logic       periph_en_o,
    input wdg_state_e state_i
);
    localparam int RW = $clog2(T_RSTPULSE + 2);
    logic [RW-1:0] run_q;

    // Length of the current reset pulse, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (state_i == ST_RSTOUT && run_q <= RW'(T_RSTPULSE))
            run_q <= run_q + 1'b1;
        else if (state_i != ST_RSTOUT)
            run_q <= '0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (host_rst_o && !periph_en_o));

    p_mode_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_MODESW && !mode_i) |=> (state_i == ST_SDIS));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(T_RSTPULSE));

    p_rst_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_o |-> (state_i == ST_PWRUP || state_i == ST_RSTOUT));

    p_wake_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_i == ST_LDIS || state_i == ST_LEN) && wake_edge_i) |=> host_rst_o);

    p_en_off_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_o |-> !periph_en_o);

    p_en_short_r12: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en_o |-> (state_i == ST_SDIS || state_i == ST_SEN));
endmodule

bind wdg_window_supervisor wdg_window_checker #(.T_RSTPULSE(T_RSTPULSE)) u_wdg_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wake_edge_i(wake_edge_i),
    .host_rst_o(host_rst_o), .periph_en_o(periph_en_o), .state_i(state_q)
);

// File: tb/wdg_window_supervisor_bench.sv
// Bench: drives the supervisor with small durations. A vector table covers the
// short-mode window rules, and directed sequences cover reset, long mode and
// the mode handshake.
module wdg_window_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T0 = 5, T1 = 8, T2 = 4, T3 = 4, T4 = 10, T5 = 6, T6 = 3;
    // Kind bits: [2] wake, [1] error, [0] good trigger.
    localparam int NV = 14;
    // Vector: gap[11:8] idle cycles after blocked-interval entry, kind[7:5],
    // settle[4:2] cycles after the check, exp_rst[1], exp_en[0].
    localparam logic [11:0] VEC [NV] = '{
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b0}, // R5 first open cycle
        {4'd7, 3'b001, 3'd0, 1'b0, 1'b0}, // R5 last open cycle
        {4'd5, 3'b001, 3'd0, 1'b0, 1'b1}, // R10 third good trigger
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b1}, // R10 saturated
        {4'd3, 3'b001, 3'd4, 1'b1, 1'b0}, // R6 last blocked cycle, R11
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b0}, // R11 count restarted
        {4'd4, 3'b010, 3'd4, 1'b1, 1'b0}, // R6 error in open interval
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b0}, // R10
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b0}, // R10
        {4'd4, 3'b001, 3'd0, 1'b0, 1'b1}, // R10
        {4'd7, 3'b000, 3'd4, 1'b1, 1'b0}, // R6 missing trigger, R11
        {4'd1, 3'b010, 3'd4, 1'b1, 1'b0}, // R6 error while blocked
        {4'd4, 3'b011, 3'd4, 1'b1, 1'b0}, // R6 error beats good trigger
        {4'd4, 3'b101, 3'd0, 1'b0, 1'b0}  // R9 wake ignored in short mode
    };

    logic clk = 1'b0, rst_n = 1'b0, mode = 1'b1;
    logic t_ok = 1'b0, t_err = 1'b0, wake = 1'b0;
    logic host_rst, periph_en;
    int   checks = 0, failures = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdg_window_supervisor #(
        .T_PWRUP(T0), .T_MODESW(T1), .T_SHORT_DIS(T2), .T_SHORT_EN(T3),
        .T_LONG_DIS(T4), .T_LONG_EN(T5), .T_RSTPULSE(T6), .GOOD_TRIG(3)
    ) u_wdg_window_supervisor (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .trig_ok_i(t_ok),
        .trig_err_i(t_err), .wake_edge_i(wake), .host_rst_o(host_rst),
        .periph_en_o(periph_en)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse(input logic [2:0] kind);
        {wake, t_err, t_ok} = kind;
        tick(1);
        {wake, t_err, t_ok} = 3'b000;
    endtask

    task automatic chk(input string req, input logic act_rst, input logic exp_rst,
                       input logic act_en, input logic exp_en);
        checks++;
        if (act_rst !== exp_rst || act_en !== exp_en) begin
            failures++;
            $display("FAIL %s: rst=%b en=%b expected rst=%b en=%b",
                     req, act_rst, act_en, exp_rst, exp_en);
        end
    endtask

    initial begin
        tick(2);
        chk("R1", host_rst, 1'b1, periph_en, 1'b0);
        rst_n = 1'b1;
        tick(T0 - 1);
        chk("R2", host_rst, 1'b1, periph_en, 1'b0);
        tick(1);
        chk("R2", host_rst, 1'b0, periph_en, 1'b0);
        tick(T1 - 1);
        chk("R3", host_rst, 1'b0, periph_en, 1'b0);
        tick(1);
        chk("R3", host_rst, 1'b1, periph_en, 1'b0);
        tick(T6 - 1);
        chk("R4", host_rst, 1'b1, periph_en, 1'b0);
        tick(1);
        chk("R4", host_rst, 1'b0, periph_en, 1'b0);
        mode = 1'b0;
        tick(1);
        chk("R3", host_rst, 1'b0, periph_en, 1'b0);

        for (int v = 0; v < NV; v++) begin
            tick(int'(VEC[v][11:8]));
            pulse(VEC[v][7:5]);
            if (VEC[v][1])      chk("R6", host_rst, 1'b1, periph_en, VEC[v][0]);
            else if (VEC[v][0]) chk("R10", host_rst, 1'b0, periph_en, 1'b1);
            else                chk("R5", host_rst, 1'b0, periph_en, 1'b0);
            tick(int'(VEC[v][4:2]));
        end

        // R9: wake in the short blocked interval, then finish the enable run.
        pulse(3'b100);
        chk("R9", host_rst, 1'b0, periph_en, 1'b0);
        tick(3);
        pulse(3'b001);
        chk("R5", host_rst, 1'b0, periph_en, 1'b0);
        tick(4);
        pulse(3'b001);
        chk("R10", host_rst, 1'b0, periph_en, 1'b1);

        // R12 / R8: long detour, good long trigger, return restores enable.
        mode = 1'b1;
        tick(1);
        chk("R12", host_rst, 1'b0, periph_en, 1'b0);
        tick(T4);
        pulse(3'b001);
        chk("R7", host_rst, 1'b0, periph_en, 1'b0);
        mode = 1'b0;
        tick(1);
        chk("R12", host_rst, 1'b0, periph_en, 1'b1);

        // R7: trigger in last long blocked cycle is a fault.
        mode = 1'b1;
        tick(1);
        tick(T4 - 1);
        pulse(3'b001);
        chk("R7", host_rst, 1'b1, periph_en, 1'b0);
        tick(T6);
        chk("R4", host_rst, 1'b0, periph_en, 1'b0);

        // R9: wake ignored in handshake, acts in long mode.
        pulse(3'b100);
        chk("R9", host_rst, 1'b0, periph_en, 1'b0);
        mode = 1'b0;
        tick(1);
        mode = 1'b1;
        tick(1);
        tick(3);
        pulse(3'b100);
        chk("R9", host_rst, 1'b1, periph_en, 1'b0);
        tick(T6);

        // R7: no trigger in the long open interval.
        mode = 1'b0;
        tick(1);
        mode = 1'b1;
        tick(1);
        tick(T4 + T5 - 1);
        chk("R7", host_rst, 1'b0, periph_en, 1'b0);
        tick(1);
        chk("R7", host_rst, 1'b1, periph_en, 1'b0);
        tick(T6);

        // R8: mode high ignored in the open interval, then switch back and forth.
        mode = 1'b0;
        tick(1);
        tick(T2);
        mode = 1'b1;
        tick(1);
        pulse(3'b001);
        chk("R8", host_rst, 1'b0, periph_en, 1'b0);
        tick(1);
        mode = 1'b0;
        tick(1);
        tick(T2);
        pulse(3'b001);
        chk("R8", host_rst, 1'b0, periph_en, 1'b0);
        tick(T2);
        pulse(3'b001);
        tick(T2);
        pulse(3'b001);
        chk("R10", host_rst, 1'b0, periph_en, 1'b1);

        // R1: reset in operation.
        rst_n = 1'b0;
        tick(1);
        chk("R1", host_rst, 1'b1, periph_en, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule